// File: doc/BRIEF.md
# IN Endpoint Packet Control

This block holds the control and status state for one device-side IN endpoint buffer. Firmware loads packet bytes into an external FIFO, and every byte written comes with a strobe that this block counts. A packet is committed to a slot either by a firmware request or, when automatic arming is on, on the write that fills a maximum-size packet. The block then presents a valid packet and the current data toggle to the serial transmit engine.

It tracks one or two packet slots, depending on the double-buffer setting. It releases the oldest slot when the protocol engine reports an ACK (bulk/interrupt) or a completed send (isochronous). It flips the DATA0/DATA1 toggle only on acknowledged bulk/interrupt transfers. A forced-toggle command flips the toggle and discards the oldest packet in a single cycle, even when an ACK arrives in that same cycle.

A small register port configures the block. The control byte carries automatic arming, endpoint type, double buffering and the forced-toggle command. A separate register holds the maximum packet size.

Top module: `in_ep_pktctl`

## Requirements
- R1: After reset, ctl_rdata reads 8'h20 (bits [5:4] = 2'b10, all other bits 0), maxp_rdata reads 0, byte_count is 0, tx_toggle is 0, and pkt_rdy, tx_valid and fifo_nempty are 0.
- R2: maxp_rdata returns the value last written through maxp_wr. That value is the packet limit in units of 8 bytes. byte_count increments by one for every fifo_wr accepted while a slot is free.
- R3: With ctl bit 0 (auto arm) set and a nonzero limit, the fifo_wr that brings the count to 8 × limit commits a packet in the same clock edge, and byte_count returns to 0.
- R4: With ctl bit 0 clear, the count passes the limit without committing a packet.
- R5: pkt_set commits a packet when a slot is free and clears byte_count to 0.
- R6: With ctl bit 2 (double buffer) clear, one slot exists; with it set, two slots exist. While no slot is free, fifo_wr and pkt_set have no effect on byte_count or occupancy.
- R7: pkt_rdy is 1 exactly when no slot is free. tx_valid and fifo_nempty are 1 whenever at least one slot is occupied.
- R8: In bulk/interrupt mode (ctl bit 1 clear), tx_ack with a packet held flips tx_toggle and releases the oldest slot. tx_sent has no effect in this mode.
- R9: In isochronous mode (ctl bit 1 set), tx_sent releases the oldest slot without flipping tx_toggle, and tx_ack has no effect.
- R10: Writing the control byte with bit 3 set flips tx_toggle once and releases the oldest slot, even when tx_ack arrives in the same cycle. Bit 3 reads back as 0.
- R11: Release events on an empty buffer leave occupancy at 0. Only the forced-toggle command still flips tx_toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [0] auto arm, [1] isochronous, [2] double buffer, [3] force toggle |
| ctl_rdata | output | 8 | Control byte readback |
| maxp_wr | input | 1 | Packet limit write strobe |
| maxp_wdata | input | MAXP_W | Packet limit in 8-byte units |
| maxp_rdata | output | MAXP_W | Packet limit readback |
| fifo_wr | input | 1 | One byte loaded into the FIFO |
| pkt_set | input | 1 | Firmware packet commit request |
| pkt_rdy | output | 1 | No free packet slot |
| fifo_nempty | output | 1 | At least one slot occupied |
| byte_count | output | CNT_W | Bytes loaded into the current packet |
| tx_sent | input | 1 | Engine finished sending a packet |
| tx_ack | input | 1 | Host acknowledged the packet |
| tx_valid | output | 1 | A packet is available to transmit |
| tx_toggle | output | 1 | Data toggle for the next packet (0 = DATA0) |

## Verification
The toggle properties assume each handshake strobe lasts one cycle and stands for one event. The bulk flip property also assumes an ACK matters only while a packet is held, so it conditions on tx_valid. The single-slot bound assumes the double-buffer bit is not rewritten in the same cycle. The stimulus raises every strobe for exactly one cycle. It never reconfigures the block in the cycle it examines a slot limit, and it drives ACKs and sends both with and without held packets, so both branches of each property are exercised.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;
  localparam int CtlAutoBit  = 0;
  localparam int CtlIsoBit   = 1;
  localparam int CtlDualBit  = 2;
  localparam int CtlForceBit = 3;
  localparam logic [1:0] CtlRsvValue = 2'b10;

  typedef struct packed {
    logic auto_arm;
    logic iso_mode;
    logic dual_slot;
  } ep_cfg_t;
endpackage

// File: rtl/in_ep_cfg_regs.sv
module in_ep_cfg_regs
  import in_ep_pkg::*;
#(
  parameter int MAXP_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              maxp_wr,
  input  logic [MAXP_W-1:0] maxp_wdata,
  output ep_cfg_t           cfg_o,
  output logic [MAXP_W-1:0] maxp_o,
  output logic              force_o,
  output logic [7:0]        ctl_rdata
);
  ep_cfg_t           cfg_q, cfg_d;
  logic [MAXP_W-1:0] maxp_q, maxp_d;

  always_comb begin
    cfg_d  = cfg_q;
    maxp_d = maxp_q;
    if (ctl_wr) begin
      cfg_d.auto_arm  = ctl_wdata[CtlAutoBit];
      cfg_d.iso_mode  = ctl_wdata[CtlIsoBit];
      cfg_d.dual_slot = ctl_wdata[CtlDualBit];
    end
    if (maxp_wr) maxp_d = maxp_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      maxp_q <= '0;
    end else begin
      if (ctl_wr)  cfg_q  <= cfg_d;
      if (maxp_wr) maxp_q <= maxp_d;
    end
  end

  always_comb begin
    ctl_rdata              = '0;
    ctl_rdata[CtlAutoBit]  = cfg_q.auto_arm;
    ctl_rdata[CtlIsoBit]   = cfg_q.iso_mode;
    ctl_rdata[CtlDualBit]  = cfg_q.dual_slot;
    ctl_rdata[5:4]         = CtlRsvValue;
  end

  assign cfg_o   = cfg_q;
  assign maxp_o  = maxp_q;
  assign force_o = ctl_wr & ctl_wdata[CtlForceBit];
endmodule

// File: rtl/in_ep_byte_cnt.sv
module in_ep_byte_cnt #(
  parameter int MAXP_W = 8,
  parameter int CNT_W  = MAXP_W + 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              fifo_wr,
  input  logic              fw_set,
  input  logic              auto_arm,
  input  logic [MAXP_W-1:0] maxp,
  input  logic              slot_free,
  output logic              commit_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int UNIT_SHIFT = 3;

  logic [CNT_W-1:0] count_q, count_d, cnt_inc, limit;
  logic             accept, auto_hit;

  always_comb begin
    limit    = CNT_W'({maxp, {UNIT_SHIFT{1'b0}}});
    accept   = fifo_wr & slot_free & ~(&count_q);
    cnt_inc  = count_q + CNT_W'(accept);
    auto_hit = auto_arm & (maxp != '0) & accept & (cnt_inc == limit);
    commit_o = slot_free & (fw_set | auto_hit);
    count_d  = commit_o ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (accept || commit_o) count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/in_ep_slot_track.sv
module in_ep_slot_track #(
  parameter int OCC_W = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             commit,
  input  logic             dual_slot,
  input  logic             iso_mode,
  input  logic             force_flip,
  input  logic             tx_sent,
  input  logic             tx_ack,
  output logic             slot_free,
  output logic             full_o,
  output logic             held_o,
  output logic             toggle_o,
  output logic [OCC_W-1:0] occ_o
);
  localparam logic [OCC_W-1:0] OneSlot = OCC_W'(1);
  localparam logic [OCC_W-1:0] TwoSlot = OCC_W'(2);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic             tog_q, tog_d;
  logic             held, release_ev, flip, occ_en;

  always_comb begin
    held       = (occ_q != '0);
    full_o     = dual_slot ? (occ_q >= TwoSlot) : (occ_q >= OneSlot);
    slot_free  = ~full_o;
    release_ev = held & (force_flip | (iso_mode ? tx_sent : tx_ack));
    flip       = force_flip | (~iso_mode & tx_ack & held);
    occ_d      = occ_q + OCC_W'(commit) - OCC_W'(release_ev);
    tog_d      = tog_q ^ flip;
    occ_en     = commit | release_ev;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      tog_q <= 1'b0;
    end else begin
      if (occ_en) occ_q <= occ_d;
      if (flip)   tog_q <= tog_d;
    end
  end

  assign held_o   = held;
  assign toggle_o = tog_q;
  assign occ_o    = occ_q;
endmodule

// File: rtl/in_ep_pktctl.sv
module in_ep_pktctl
  import in_ep_pkg::*;
#(
  parameter int MAXP_W = 8,
  parameter int CNT_W  = MAXP_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              maxp_wr,
  input  logic [MAXP_W-1:0] maxp_wdata,
  output logic [MAXP_W-1:0] maxp_rdata,
  input  logic              fifo_wr,
  input  logic              pkt_set,
  output logic              pkt_rdy,
  output logic              fifo_nempty,
  output logic [CNT_W-1:0]  byte_count,
  input  logic              tx_sent,
  input  logic              tx_ack,
  output logic              tx_valid,
  output logic              tx_toggle
);
  localparam int OCC_W  = 2;
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_sync_n;
  ep_cfg_t           cfg;
  logic [MAXP_W-1:0] maxp;
  logic              force_flip, slot_free, commit, full, held;
  logic [OCC_W-1:0]  occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_N-1];

  in_ep_cfg_regs #(.MAXP_W(MAXP_W)) u_cfg (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .maxp_wr    (maxp_wr),
    .maxp_wdata (maxp_wdata),
    .cfg_o      (cfg),
    .maxp_o     (maxp),
    .force_o    (force_flip),
    .ctl_rdata  (ctl_rdata)
  );

  in_ep_byte_cnt #(.MAXP_W(MAXP_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .fifo_wr   (fifo_wr),
    .fw_set    (pkt_set),
    .auto_arm  (cfg.auto_arm),
    .maxp      (maxp),
    .slot_free (slot_free),
    .commit_o  (commit),
    .count_o   (byte_count)
  );

  in_ep_slot_track #(.OCC_W(OCC_W)) u_slots (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .commit     (commit),
    .dual_slot  (cfg.dual_slot),
    .iso_mode   (cfg.iso_mode),
    .force_flip (force_flip),
    .tx_sent    (tx_sent),
    .tx_ack     (tx_ack),
    .slot_free  (slot_free),
    .full_o     (full),
    .held_o     (held),
    .toggle_o   (tx_toggle),
    .occ_o      (occ)
  );

  assign maxp_rdata  = maxp;
  assign pkt_rdy     = full;
  assign fifo_nempty = held;
  assign tx_valid    = held;
endmodule

// File: rtl/in_ep_pktctl_chk.sv
module in_ep_pktctl_chk #(
  parameter int CNT_W = 11,
  parameter int OCC_W = 2
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             iso_mode,
  input logic             dual_slot,
  input logic             force_flip,
  input logic             ctl_wr,
  input logic             tx_ack,
  input logic             tx_valid,
  input logic             tx_toggle,
  input logic             pkt_rdy,
  input logic [CNT_W-1:0] byte_count,
  input logic [OCC_W-1:0] occ
);
  // R5: a new packet entering a slot leaves the counter cleared
  p_cnt_clear_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (occ > $past(occ)) |-> (byte_count == '0));

  // R6: no loading while full
  p_full_holds_count_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    pkt_rdy |=> $stable(byte_count));

  // R6: single-slot mode never exceeds one packet
  p_single_bound_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!dual_slot && occ <= OCC_W'(1) && !ctl_wr) |=> (occ <= OCC_W'(1)));

  // R7: full implies a valid packet for the engine
  p_rdy_has_valid_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    pkt_rdy |-> tx_valid);

  // R8: acknowledged bulk packet flips the toggle
  p_bulk_ack_flip_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!iso_mode && tx_ack && tx_valid && !force_flip) |=> (tx_toggle != $past(tx_toggle)));

  // R9: isochronous traffic leaves the toggle alone
  p_iso_toggle_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (iso_mode && !force_flip) |=> $stable(tx_toggle));

  // R10: forced toggle flips exactly once
  p_force_flip_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    force_flip |=> (tx_toggle != $past(tx_toggle)));
endmodule

bind in_ep_pktctl in_ep_pktctl_chk #(.CNT_W(CNT_W), .OCC_W(2)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .iso_mode   (cfg.iso_mode),
  .dual_slot  (cfg.dual_slot),
  .force_flip (force_flip),
  .ctl_wr     (ctl_wr),
  .tx_ack     (tx_ack),
  .tx_valid   (tx_valid),
  .tx_toggle  (tx_toggle),
  .pkt_rdy    (pkt_rdy),
  .byte_count (byte_count),
  .occ        (occ)
);

// File: tb/test_in_ep_pktctl.sv
module test_in_ep_pktctl;
  localparam int MAXP_W = 8;
  localparam int CNT_W  = MAXP_W + 3;

  logic              clk, rst_n;
  logic              ctl_wr, maxp_wr, fifo_wr, pkt_set, tx_sent, tx_ack;
  logic [7:0]        ctl_wdata, ctl_rdata;
  logic [MAXP_W-1:0] maxp_wdata, maxp_rdata;
  logic              pkt_rdy, fifo_nempty, tx_valid, tx_toggle;
  logic [CNT_W-1:0]  byte_count;

  typedef struct {
    logic [CNT_W-1:0]  cnt;
    logic              rdy;
    logic              vld;
    logic              tog;
    logic [7:0]        rd;
    logic [MAXP_W-1:0] mx;
    string             req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;

  // bench-side view of the requirements
  bit             m_auto, m_iso, m_dual, m_tog;
  int             m_cnt, m_occ;
  int unsigned    m_maxp;

  in_ep_pktctl #(.MAXP_W(MAXP_W)) i_in_ep_pktctl (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .ctl_rdata, .maxp_wr, .maxp_wdata,
    .maxp_rdata, .fifo_wr, .pkt_set, .pkt_rdy, .fifo_nempty, .byte_count,
    .tx_sent, .tx_ack, .tx_valid, .tx_toggle
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic cmp(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.req, "byte_count", int'(byte_count), int'(e.cnt));
        cmp(e.req, "pkt_rdy", int'(pkt_rdy), int'(e.rdy));
        cmp(e.req, "tx_valid", int'(tx_valid), int'(e.vld));
        cmp(e.req, "fifo_nempty", int'(fifo_nempty), int'(e.vld));
        cmp(e.req, "tx_toggle", int'(tx_toggle), int'(e.tog));
        cmp(e.req, "ctl_rdata", int'(ctl_rdata), int'(e.rd));
        cmp(e.req, "maxp_rdata", int'(maxp_rdata), int'(e.mx));
      end
    end
  end

  // driver: drives one cycle and pushes the expected result
  task automatic step(bit cw, logic [7:0] cd, bit mw, logic [7:0] md,
                      bit fw, bit ps, bit snt, bit ak, string req);
    int  cap, ncnt;
    bit  free, acc, commit, frc, rel, flip;
    exp_t e;
    @(negedge clk);
    ctl_wr = cw; ctl_wdata = cd; maxp_wr = mw; maxp_wdata = md;
    fifo_wr = fw; pkt_set = ps; tx_sent = snt; tx_ack = ak;
    cap    = m_dual ? 2 : 1;
    free   = (m_occ < cap);
    acc    = fw && free;
    ncnt   = m_cnt + int'(acc);
    commit = free && (ps || (m_auto && m_maxp != 0 && acc && ncnt == int'(m_maxp * 8)));
    frc    = cw && cd[3];
    rel    = (m_occ != 0) && (frc || (m_iso ? snt : ak));
    flip   = frc || (!m_iso && ak && m_occ != 0);
    m_occ  = m_occ + int'(commit) - int'(rel);
    m_cnt  = commit ? 0 : ncnt;
    m_tog  = m_tog ^ flip;
    if (cw) begin m_auto = cd[0]; m_iso = cd[1]; m_dual = cd[2]; end
    if (mw) m_maxp = md;
    cap   = m_dual ? 2 : 1;
    e.cnt = CNT_W'(m_cnt);
    e.rdy = (m_occ >= cap);
    e.vld = (m_occ != 0);
    e.tog = m_tog;
    e.rd  = {2'b00, 2'b10, 1'b0, m_dual, m_iso, m_auto};
    e.mx  = MAXP_W'(m_maxp);
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(string req);
    step(0, 8'h00, 0, 8'h00, 0, 0, 0, 0, req);
  endtask
  task automatic set_ctl(logic [7:0] d, string req);
    step(1, d, 0, 8'h00, 0, 0, 0, 0, req);
  endtask
  task automatic load(int n, string req);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, 1, 0, 0, 0, req);
  endtask
  task automatic ack(string req);
    step(0, 8'h00, 0, 8'h00, 0, 0, 0, 1, req);
  endtask
  task automatic sent(string req);
    step(0, 8'h00, 0, 8'h00, 0, 0, 1, 0, req);
  endtask
  task automatic fw_set(string req);
    step(0, 8'h00, 0, 8'h00, 0, 1, 0, 0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctl_wr = 0; ctl_wdata = 0; maxp_wr = 0; maxp_wdata = 0;
    fifo_wr = 0; pkt_set = 0; tx_sent = 0; tx_ack = 0;
    m_auto = 0; m_iso = 0; m_dual = 0; m_tog = 0; m_cnt = 0; m_occ = 0; m_maxp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    idle("R1");                                       // reset state
    step(0, 8'h00, 1, 8'h01, 0, 0, 0, 0, "R2");       // limit 8 bytes
    load(5, "R2");
    load(4, "R4");                                    // passes 8 without commit
    fw_set("R5");                                     // commit, count cleared
    load(2, "R6");                                    // full: writes ignored
    fw_set("R6");                                     // full: request ignored
    sent("R8");                                       // bulk: sent ignored
    ack("R8");                                        // release + flip
    set_ctl(8'h01, "R3");                             // auto arm
    load(7, "R3");
    load(1, "R3");                                    // 8th byte commits
    ack("R8");
    set_ctl(8'h05, "R6");                             // double buffer
    load(8, "R7");                                    // one slot held, not ready
    load(8, "R6");                                    // second slot, ready
    load(1, "R6");
    step(1, 8'h0D, 0, 8'h00, 0, 0, 0, 1, "R10");      // force with ACK
    ack("R8");
    ack("R11");                                       // empty: no flip
    set_ctl(8'h0D, "R11");                            // force on empty flips
    set_ctl(8'h07, "R9");                             // isochronous
    step(0, 8'h00, 1, 8'h02, 0, 0, 0, 0, "R2");       // limit 16 bytes
    load(16, "R9");
    ack("R9");                                        // ignored in iso
    sent("R9");                                       // release, no flip
    sent("R11");
    step(1, 8'h30, 0, 8'h00, 0, 0, 0, 0, "R1");       // reserved field fixed
    idle("R10");

    @(negedge clk);
    ctl_wr = 0; fifo_wr = 0; pkt_set = 0; tx_sent = 0; tx_ack = 0; maxp_wr = 0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule